// File: doc/BRIEF.md
# DMA Request and Acknowledge Sequencer

This block is the control sequencer of one DMA channel. It watches an external request line, decides when to run bus transfers, and drives a simplified bus-cycle handshake. The handshake has a one-clock start strobe, a direction line and a returned acknowledge. The block also drives an indication of bus ownership, a dual-address mode flag and an external acknowledge strobe. Address generation, the data path and bus arbitration are outside this block. A transfer counter loaded through the configuration port stands in for them.

Software writes one configuration word. The word holds a run bit, the cycle-steal or burst choice, the single-address or dual-address choice, the acknowledge-timing choice and a transfer count. In cycle-steal mode each recognised request produces one transfer. In burst mode one request runs the whole block.

Between transfers the channel always hands the bus back for at least one clock. This leaves room for processor cycles. When the count runs out, a done flag rises. The channel then stays locked until the configuration is written again.

Top module: `dma_req_seq`

## Requirements
- R1: A request is recognised when `req_in` is high on one rising clock edge while the channel is idle; a one-clock pulse is enough.
- R2: With `cfg_ack_last`=1, `ack_out` is high only during the bus cycles of the final transfer of the block (for a dual-address block, both of its cycles).
- R3: With `cfg_ack_last`=0, `ack_out` is high during every DMA bus cycle.
- R4: In cycle-steal mode (`cfg_burst`=0), each recognised request produces exactly one transfer.
- R5: In burst mode (`cfg_burst`=1), one recognised request runs all programmed transfers, and `req_in` has no effect once the block has started.
- R6: `blk_done` rises in the cycle after the acknowledge of the last transfer. While it is set, no transfer starts. A configuration write clears it.
- R7: `owner_dma` is 1 while the DMA holds the bus and 0 otherwise, including at least one clock between consecutive transfers. `mode_dual` is 1 during dual-address transfers only.
- R8: A dual-address transfer is a read cycle (`cyc_read`=1) followed by a write cycle (`cyc_read`=0). A single-address transfer is one write cycle. Each cycle raises `cyc_start` for one clock and then waits for `cyc_ack` before it advances.
- R9: In cycle-steal mode, `req_in` high on the edge where the start strobe of the final cycle of a transfer is high counts as a new request. This is the write cycle in dual-address mode and the only cycle in single-address mode. During the read cycle of a dual-address transfer, `req_in` is not sampled.
- R10: A programmed count of zero starts no transfer and does not set `blk_done`.
- R11: After reset the channel is idle, with `owner_dma`, `ack_out`, `cyc_start` and `blk_done` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_run | input | 1 | Channel enable written with the configuration |
| cfg_burst | input | 1 | 1 = burst, 0 = cycle-steal |
| cfg_dual | input | 1 | 1 = dual-address, 0 = single-address |
| cfg_ack_last | input | 1 | 1 = acknowledge on final transfer only |
| cfg_count | input | CNT_W | Number of transfers in the block |
| req_in | input | 1 | External transfer request |
| cyc_ack | input | 1 | Bus-cycle acknowledge |
| cyc_start | output | 1 | One-clock bus-cycle start strobe |
| cyc_read | output | 1 | 1 = read cycle, 0 = write cycle |
| owner_dma | output | 1 | 1 = DMA owns the bus, 0 = processor |
| mode_dual | output | 1 | Dual-address transfer in progress |
| ack_out | output | 1 | External acknowledge strobe |
| blk_done | output | 1 | Block complete |

## Verification
The assertions assume that `cyc_ack` comes only while a bus cycle is waiting and never in the same clock as its start strobe. They also assume that configuration writes land only while the channel is idle. The bus responder in the bench answers each start strobe after a set latency of at least one clock, and every configuration write is issued after the previous block has gone quiet. Request pulses are driven between clock edges, held for a known number of edges, and dropped before any configuration write.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_ST,
        S_RD_WT,
        S_WR_ST,
        S_WR_WT
    } seq_state_t;

    typedef struct packed {
        logic run;
        logic burst;
        logic dual;
        logic ack_last;
    } chan_cfg_t;

    function automatic logic is_strobe(seq_state_t s);
        return (s == S_RD_ST) || (s == S_WR_ST);
    endfunction

    function automatic logic is_read(seq_state_t s);
        return (s == S_RD_ST) || (s == S_RD_WT);
    endfunction

endpackage

// File: rtl/dma_req_latch.sv
module dma_req_latch (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic req,
    input  logic window,
    input  logic take,
    output logic req_now
);
    logic pending;

    assign req_now = pending | (req & window);

    always_ff @(posedge clk) begin
        if (rst || clr)
            pending <= 1'b0;
        else
            pending <= req_now & ~take;
    end

    // R9
    no_sample_outside_chk: assert property (@(posedge clk) disable iff (rst)
        (!window && !pending) |=> !pending);

endmodule

// File: rtl/dma_blk_count.sv
module dma_blk_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         last,
    output logic         empty
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] remaining;

    always_ff @(posedge clk) begin
        if (rst)
            remaining <= '0;
        else if (load)
            remaining <= load_val;
        else if (dec && remaining != '0)
            remaining <= remaining - ONE;
    end

    assign last  = (remaining == ONE);
    assign empty = (remaining == '0);

    // R6
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !dec) |=> $stable(remaining));

endmodule

// File: rtl/dma_bus_fsm.sv
module dma_bus_fsm
    import dma_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       abort,
    input  logic       go,
    input  logic       dual,
    input  logic       ack,
    output seq_state_t state,
    output logic       xfer_end
);
    seq_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (go) nxt = dual ? S_RD_ST : S_WR_ST;
            S_RD_ST: nxt = S_RD_WT;
            S_RD_WT: if (ack) nxt = S_WR_ST;
            S_WR_ST: nxt = S_WR_WT;
            S_WR_WT: if (ack) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
        if (abort) nxt = S_IDLE;
    end

    assign xfer_end = (state == S_WR_WT) && ack && !abort;

    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= nxt;
    end

    // R8
    strobe_once_chk: assert property (@(posedge clk) disable iff (rst)
        is_strobe(state) |=> !is_strobe(state));

    // R8
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_RD_WT && !ack && !abort) |=> state == S_RD_WT);

endmodule

// File: rtl/dma_req_seq.sv
module dma_req_seq
    import dma_seq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic             cfg_run,
    input  logic             cfg_burst,
    input  logic             cfg_dual,
    input  logic             cfg_ack_last,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic             req_in,
    input  logic             cyc_ack,
    output logic             cyc_start,
    output logic             cyc_read,
    output logic             owner_dma,
    output logic             mode_dual,
    output logic             ack_out,
    output logic             blk_done
);
    chan_cfg_t  cfg;
    seq_state_t state;
    logic idle, window, go, req_now, xfer_end, last, empty, burst_run;

    always_ff @(posedge clk) begin
        if (rst)
            cfg <= '0;
        else if (cfg_we)
            cfg <= '{run: cfg_run, burst: cfg_burst, dual: cfg_dual, ack_last: cfg_ack_last};
    end

    assign idle   = (state == S_IDLE);
    assign window = (idle & ~burst_run) | (~cfg.burst & (state == S_WR_ST));
    assign go     = idle & cfg.run & ~blk_done & ~empty & ~cfg_we
                  & (burst_run | req_now);

    dma_req_latch u_req (
        .clk    (clk),
        .rst    (rst),
        .clr    (cfg_we),
        .req    (req_in),
        .window (window),
        .take   (go),
        .req_now(req_now)
    );

    dma_blk_count #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .load    (cfg_we),
        .load_val(cfg_count),
        .dec     (xfer_end),
        .last    (last),
        .empty   (empty)
    );

    dma_bus_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .abort   (cfg_we),
        .go      (go),
        .dual    (cfg.dual),
        .ack     (cyc_ack),
        .state   (state),
        .xfer_end(xfer_end)
    );

    always_ff @(posedge clk) begin
        if (rst || cfg_we) begin
            burst_run <= 1'b0;
            blk_done  <= 1'b0;
        end else begin
            if (xfer_end && last) begin
                burst_run <= 1'b0;
                blk_done  <= 1'b1;
            end else if (go && cfg.burst) begin
                burst_run <= 1'b1;
            end
        end
    end

    assign owner_dma = ~idle;
    assign mode_dual = ~idle & cfg.dual;
    assign cyc_start = is_strobe(state);
    assign cyc_read  = is_read(state);
    assign ack_out   = ~idle & (~cfg.ack_last | last);

    // R6
    done_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (blk_done && !cfg_we) |=> !owner_dma);

    // R6
    done_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(blk_done) |-> $past(cyc_ack));

    // R7
    tenure_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(owner_dma) |-> cyc_start);

    // R10
    empty_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (empty && idle && !cfg_we) |=> !owner_dma);

endmodule

// File: tb/dma_req_seq_test.sv
module dma_req_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 8;

    logic clk = 0, rst = 1;
    logic cfg_we = 0, cfg_run = 0, cfg_burst = 0, cfg_dual = 0, cfg_ack_last = 0;
    logic [CNT_W-1:0] cfg_count = '0;
    logic req_in = 0, cyc_ack = 0;
    logic cyc_start, cyc_read, owner_dma, mode_dual, ack_out, blk_done;

    int checks = 0, errors = 0, lat = 1;
    int n_st = 0, n_rd = 0, n_dual = 0, n_ack = 0, n_rel = 0;
    logic prev_own = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_req_seq #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_run(cfg_run),
        .cfg_burst(cfg_burst), .cfg_dual(cfg_dual), .cfg_ack_last(cfg_ack_last),
        .cfg_count(cfg_count), .req_in(req_in), .cyc_ack(cyc_ack),
        .cyc_start(cyc_start), .cyc_read(cyc_read), .owner_dma(owner_dma),
        .mode_dual(mode_dual), .ack_out(ack_out), .blk_done(blk_done)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (cyc_start) begin
                n_st++;
                if (cyc_read)  n_rd++;
                if (mode_dual) n_dual++;
                if (ack_out)   n_ack++;
            end
            if (prev_own && !owner_dma) n_rel++;
            prev_own <= owner_dma;
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            cyc_ack <= 1'b0;
            if (!rst && cyc_start) begin
                repeat (lat) @(negedge clk);
                cyc_ack <= 1'b1;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic run, input logic burst, input logic dual,
                             input logic ackl, input int cnt);
        @(negedge clk);
        cfg_we = 1; cfg_run = run; cfg_burst = burst; cfg_dual = dual;
        cfg_ack_last = ackl; cfg_count = CNT_W'(cnt);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic req_hold(input int edges);
        @(negedge clk);
        req_in = 1;
        repeat (edges) @(negedge clk);
        req_in = 0;
    endtask

    task automatic t_reset;
        chk("R11 owner_dma", owner_dma, 0);
        chk("R11 ack_out", ack_out, 0);
        chk("R11 cyc_start", cyc_start, 0);
        chk("R11 blk_done", blk_done, 0);
    endtask

    task automatic t_steal_dual;
        int s0, r0, d0, a0;
        lat = 1;
        write_cfg(1, 0, 1, 0, 3);
        s0 = n_st; r0 = n_rd; d0 = n_dual; a0 = n_ack;
        req_hold(1);
        repeat (20) @(negedge clk);
        chk("R1 R4 one transfer strobes", n_st - s0, 2);
        chk("R8 read then write", n_rd - r0, 1);
        chk("R7 mode_dual on strobes", n_dual - d0, 2);
        chk("R3 ack on every cycle", n_ack - a0, 2);
        chk("R6 done not yet", blk_done, 0);
        req_hold(1); repeat (20) @(negedge clk);
        req_hold(1); repeat (20) @(negedge clk);
        chk("R4 three requests strobes", n_st - s0, 6);
        chk("R6 done after block", blk_done, 1);
    endtask

    task automatic t_lockout;
        int s0;
        s0 = n_st;
        req_hold(1);
        repeat (20) @(negedge clk);
        chk("R6 locked after done", n_st - s0, 0);
        write_cfg(1, 0, 0, 0, 1);
        chk("R6 write clears done", blk_done, 0);
        repeat (5) @(negedge clk);
        chk("R6 no transfer without request", n_st - s0, 0);
    endtask

    task automatic t_steal_single_rereq;
        int s0, r0, d0;
        lat = 1;
        write_cfg(1, 0, 0, 0, 4);
        s0 = n_st; r0 = n_rd; d0 = n_dual;
        req_hold(2);
        repeat (25) @(negedge clk);
        chk("R9 single rerequest strobes", n_st - s0, 2);
        chk("R8 single uses write", n_rd - r0, 0);
        chk("R7 mode_dual low single", n_dual - d0, 0);
    endtask

    task automatic t_steal_dual_hold;
        int s0;
        lat = 1;
        write_cfg(1, 0, 1, 0, 4);
        s0 = n_st;
        req_hold(2);
        repeat (25) @(negedge clk);
        chk("R9 dual read not sampled", n_st - s0, 2);
    endtask

    task automatic t_burst_single;
        int s0, l0;
        lat = 2;
        write_cfg(1, 1, 0, 0, 4);
        s0 = n_st; l0 = n_rel;
        req_hold(1);
        repeat (60) @(negedge clk);
        chk("R5 burst from one pulse", n_st - s0, 4);
        chk("R7 bus released per transfer", n_rel - l0, 4);
        chk("R6 burst done", blk_done, 1);
    endtask

    task automatic t_burst_dual_last;
        int s0, a0;
        lat = 1;
        write_cfg(1, 1, 1, 1, 3);
        s0 = n_st; a0 = n_ack;
        @(negedge clk); req_in = 1;
        repeat (60) @(negedge clk);
        chk("R5 burst ignores held request", n_st - s0, 6);
        chk("R2 ack final transfer only", n_ack - a0, 2);
        chk("R6 burst dual done", blk_done, 1);
        req_in = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_zero;
        int s0;
        write_cfg(1, 0, 1, 0, 0);
        s0 = n_st;
        req_hold(1);
        repeat (20) @(negedge clk);
        chk("R10 zero count no transfer", n_st - s0, 0);
        chk("R10 zero count no done", blk_done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_steal_dual();
        t_lockout();
        t_steal_single_rereq();
        t_steal_dual_hold();
        t_burst_single();
        t_burst_dual_last();
        t_zero();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule